// File: doc/BRIEF.md
# Serial Byte Transmitter with Read-Armed Empty Flag

This block is the transmit half of an 8-bit asynchronous serial port behind a small byte-wide register interface. Software places a byte in a holding register. On the next baud tick the byte moves into a shift register, which drives one frame onto an idle-high line. A frame is a low start bit, then the data least significant bit first, then a high stop bit.

Two status flags report progress. The empty flag is a level: it is high whenever the holding register can take a byte. The complete flag tells software that the shifter has finished its last stop bit and that no byte is waiting. The interrupt output is the level AND of the empty flag and an interrupt enable, so it stays high for as long as software leaves the holding register empty with interrupts enabled.

The empty flag only drops after a two-step handshake. First a status read must see the flag set, which arms the clear. Then a data write consumes the arm and loads the byte. A data write that finds no arm is ignored. The bit rate is the clock divided by a fixed prescaler times (divisor + 1). With the defaults this gives 100 kbaud from a 48 MHz clock.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high, the interrupt is low, the status register (offset 0) reads 0x03, the control register (offset 1) reads 0, and the divisor register (offset 3) reads RESET_DIV.
- R2: Each frame is one 0 start bit, DATA_W data bits least significant bit first, and one 1 stop bit. Every bit lasts (divisor + 1) * PRESCALE clock cycles.
- R3: The interrupt output equals control bit 1 (interrupt enable) AND status bit 0 (empty). It holds that level for as long as both inputs stay unchanged.
- R4: A write to the data register (offset 2) that is not preceded by a status read that saw the empty flag set has no effect. The empty flag stays 1 and no frame starts.
- R5: A status read that sees the empty flag set, followed by a data write, loads the byte and clears the empty flag on that write's clock edge. The write consumes the arm, so a second data write made without a new status read is ignored. The arm never persists while the empty flag is 0.
- R6: After a qualifying write into an idle transmitter, the byte moves to the shift register on the next baud tick, 1 to (divisor + 1) * PRESCALE cycles later. The empty flag rises on the same edge that the start bit goes onto the line.
- R7: The complete flag (status bit 1) is 0 from a qualifying write until the transmitter is idle with nothing pending. It stays 0 across back-to-back frames. It rises on the edge that ends the last stop bit.
- R8: Clearing the transmit enable (control bit 0) lets the frame in progress finish and then leaves the line high. A byte waiting in the holding register is discarded, which returns the empty flag to 1.
- R9: The divisor register can be written and read back, and a new value changes the bit time of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register offset: 0 status, 1 control, 2 data, 3 divisor |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data (combinational, data offset reads 0) |
| tx_line | output | 1 | Serial output, idle high |
| tx_irq | output | 1 | Level transmit interrupt request |

## Verification
Register reads return the current state in the same cycle. A write takes effect on the edge that samples it, so the bench checks the interrupt level half a cycle after that edge to confirm the empty flag dropped. The reload into the shifter is due on the next baud tick. The bench counts cycles until the interrupt rises again, requires the count to lie between 1 and one bit time, and requires the start bit to be on the line in that same cycle. A line monitor samples each bit at the middle of its window from the detected start edge. Status reads for the complete flag wait one full bit time past the last mid-stop sample, so they fall after the edge that ends the stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam logic [1:0] ADR_STAT = 2'd0;
   localparam logic [1:0] ADR_CTRL = 2'd1;
   localparam logic [1:0] ADR_DATA = 2'd2;
   localparam logic [1:0] ADR_DIV  = 2'd3;

   localparam int ST_EMPTY = 0;
   localparam int ST_DONE  = 1;
   localparam int CT_EN    = 0;
   localparam int CT_IE    = 1;

   typedef enum logic {SH_IDLE, SH_BUSY} sh_state_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int PRESCALE = 4,
   parameter int DIV_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic pre_tick;

   generate
      if (PRESCALE < 1) begin : g_bad_pre
         $error("sertx_baud: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_no_pre
         assign pre_tick = 1'b1;
      end else begin : g_pre
         localparam int PW = $clog2(PRESCALE);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pcnt <= '0;
            else if (pcnt == PW'(PRESCALE - 1))  pcnt <= '0;
            else                                 pcnt <= pcnt + 1'b1;
         end
         assign pre_tick = (pcnt == PW'(PRESCALE - 1));
      end
   endgenerate

   logic [DIV_W-1:0] dcnt;
   logic             at_end;

   assign at_end = (dcnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dcnt <= '0;
      else if (pre_tick) dcnt <= at_end ? '0 : dcnt + 1'b1;
   end

   assign tick = pre_tick & at_end;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic              pending,
   input  logic [DATA_W-1:0] hold,
   output logic              line,
   output logic              take,
   output logic              done,
   output logic              busy
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int IW         = $clog2(FRAME_BITS);

   sh_state_e     st;
   logic [IW-1:0] idx;
   logic [DATA_W:0] sh;
   logic          line_q;
   logic          last;

   assign busy = (st == SH_BUSY);
   assign last = busy && (idx == IW'(FRAME_BITS - 1));
   assign take = tick & enable & pending & (!busy | last);
   assign done = tick & last & !take;
   assign line = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SH_IDLE;
         idx    <= '0;
         sh     <= '1;
         line_q <= 1'b1;
      end else if (take) begin
         sh     <= {1'b1, hold};
         line_q <= 1'b0;
         idx    <= '0;
         st     <= SH_BUSY;
      end else if (done) begin
         st     <= SH_IDLE;
         line_q <= 1'b1;
         idx    <= '0;
      end else if (tick && busy) begin
         line_q <= sh[0];
         sh     <= {1'b1, sh[DATA_W:1]};
         idx    <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PRESCALE  = 4,
   parameter int RESET_DIV = 119
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              tx_line,
   output logic              tx_irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sertx_core: DATA_W must be at least 2");
      end
      if (RESET_DIV < 0 || RESET_DIV >= (1 << DATA_W)) begin : g_bad_div
         $error("sertx_core: RESET_DIV does not fit the divisor register");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q, div_q;
   logic empty_q, done_q, arm_q, en_q, ie_q;
   logic empty_d, done_d, arm_d;
   logic tick, sh_take, sh_done, sh_busy;
   logic rd_stat, wr_ctrl, wr_data, wr_div, qual_wr, discard;

   assign rd_stat = acc_en & !acc_wr & (acc_addr == ADR_STAT);
   assign wr_ctrl = acc_en &  acc_wr & (acc_addr == ADR_CTRL);
   assign wr_data = acc_en &  acc_wr & (acc_addr == ADR_DATA);
   assign wr_div  = acc_en &  acc_wr & (acc_addr == ADR_DIV);
   assign qual_wr = wr_data & arm_q;
   assign discard = !en_q & !empty_q;

   sertx_baud #(.PRESCALE(PRESCALE), .DIV_W(DATA_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
   );

   sertx_shift #(.DATA_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_q),
      .pending(!empty_q), .hold(hold_q), .line(tx_line),
      .take(sh_take), .done(sh_done), .busy(sh_busy)
   );

   always_comb begin
      empty_d = empty_q;
      if (sh_take || discard) empty_d = 1'b1;
      if (qual_wr)            empty_d = 1'b0;

      done_d = done_q;
      if (qual_wr || sh_take)            done_d = 1'b0;
      if (sh_done || (discard && !sh_busy)) done_d = 1'b1;

      arm_d = arm_q;
      if (rd_stat && empty_q) arm_d = 1'b1;
      if (wr_data)            arm_d = 1'b0;
      if (!empty_d)           arm_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         done_q  <= 1'b1;
         arm_q   <= 1'b0;
         en_q    <= 1'b0;
         ie_q    <= 1'b0;
         hold_q  <= '0;
         div_q   <= DATA_W'(RESET_DIV);
      end else begin
         empty_q <= empty_d;
         done_q  <= done_d;
         arm_q   <= arm_d;
         if (qual_wr) hold_q <= acc_wdata;
         if (wr_ctrl) begin
            en_q <= acc_wdata[CT_EN];
            ie_q <= acc_wdata[CT_IE];
         end
         if (wr_div) div_q <= acc_wdata;
      end
   end

   always_comb begin
      acc_rdata = '0;
      unique case (acc_addr)
         ADR_STAT: begin
            acc_rdata[ST_EMPTY] = empty_q;
            acc_rdata[ST_DONE]  = done_q;
         end
         ADR_CTRL: begin
            acc_rdata[CT_EN] = en_q;
            acc_rdata[CT_IE] = ie_q;
         end
         ADR_DIV:  acc_rdata = div_q;
         default:  acc_rdata = '0;
      endcase
   end

   assign tx_irq = ie_q & empty_q;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic take,
   input logic line,
   input logic busy,
   input logic empty,
   input logic arm,
   input logic done_flag,
   input logic wr_data
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line);

   p_unqual_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !arm && empty) |=> empty);

   p_qual_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && arm) |=> !empty);

   p_arm_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> empty);

   p_take_starts_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!line && empty));

   p_complete_means_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag |-> !busy);
endmodule

bind sertx_core sertx_chk i_chk (
   .clk(clk), .rst_n(rst_n), .take(sh_take), .line(tx_line), .busy(sh_busy),
   .empty(empty_q), .arm(arm_q), .done_flag(done_q), .wr_data(wr_data)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
   localparam int DW = 8;
   localparam logic [1:0] A_STAT = 2'd0, A_CTRL = 2'd1, A_DATA = 2'd2, A_DIV = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_en = 1'b0, acc_wr = 1'b0;
   logic [1:0] acc_addr = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] acc_rdata;
   logic tx_line, tx_irq;

   int vectors = 0;
   int fails = 0;
   int T = 120;
   int stop_err = 0;
   bit finished = 0;
   logic [7:0] rxq[$];

   always #5 clk = ~clk;

   sertx_core #(.DATA_W(DW), .PRESCALE(1), .RESET_DIV(119)) i_sertx_core (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .tx_line(tx_line), .tx_irq(tx_irq)
   );

   // line monitor: samples each bit mid-window from the detected start
   bit in_fr = 0;
   int mph = 0;
   logic [7:0] msh;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!in_fr) begin
            if (!tx_line) begin in_fr = 1; mph = 0; end
         end else begin
            mph++;
            if (mph % T == T / 2) begin
               int k;
               k = mph / T;
               if (k == 0 && tx_line) stop_err++;
               else if (k >= 1 && k <= 8) msh[k-1] = tx_line;
               else if (k == 9) begin
                  if (!tx_line) stop_err++;
                  rxq.push_back(msh);
                  in_fr = 0;
               end
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 0; acc_wr = 0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      acc_en = 1; acc_wr = 0; acc_addr = a;
      #1 d = acc_rdata;
      @(negedge clk);
      acc_en = 0;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!tx_irq && n < 4 * T) begin @(negedge clk); n++; end
   endtask

   task automatic wait_frame(input string req, input logic [7:0] exp);
      int n;
      n = 0;
      while (rxq.size() == 0 && n < 40 * T) begin @(negedge clk); n++; end
      if (rxq.size() == 0) check({req, " frame seen"}, 0, 1);
      else check(req, rxq.pop_front(), exp);
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] r;
      int n;
      bus_read(A_STAT, r);
      check("R5 empty set before load", r[0], 1);
      bus_write(A_DATA, b);
      check("R5 empty drops on write", tx_irq, 0);
      wait_irq(n);
      check("R6 reload within one bit time", (n >= 1 && n <= T), 1);
      check("R6 start bit with reload", tx_line, 0);
      wait_frame("R2 frame byte", b);
      repeat (T) @(negedge clk);
      bus_read(A_STAT, r);
      check("R7 complete after last stop", r, 8'h03);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int n, lows;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 line idle", tx_line, 1);
      check("R1 irq low", tx_irq, 0);
      bus_read(A_CTRL, r); check("R1 control", r, 0);
      bus_read(A_DIV, r);  check("R1 divisor", r, 119);

      bus_write(A_DIV, 8'd2); T = 3;
      bus_write(A_CTRL, 8'h03);

      // R4 unarmed data write is ignored
      bus_write(A_DATA, 8'h55);
      check("R4 empty stays set", tx_irq, 1);
      lows = 0;
      for (int i = 0; i < 4 * T; i++) begin @(negedge clk); if (!tx_line) lows++; end
      check("R4 no frame", lows, 0);
      check("R4 no byte", rxq.size(), 0);
      bus_read(A_STAT, r); check("R1 status", r, 8'h03);

      // R3 level interrupt
      lows = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (!tx_irq) lows++; end
      check("R3 irq held", lows, 0);
      bus_write(A_CTRL, 8'h01); check("R3 irq masked", tx_irq, 0);
      bus_write(A_CTRL, 8'h03); check("R3 irq unmasked", tx_irq, 1);

      // R2/R6 sweep over all byte values
      for (int b = 0; b < 256; b++) send(8'(b));

      // R5 arm consumed by the first write
      bus_read(A_STAT, r);
      bus_write(A_DATA, 8'h3C);
      bus_write(A_DATA, 8'hC3);
      wait_frame("R5 first byte kept", 8'h3C);
      repeat (12 * T) @(negedge clk);
      check("R5 second write ignored", rxq.size(), 0);
      check("R5 line idle", tx_line, 1);
      bus_read(A_STAT, r); check("R5 status idle", r, 8'h03);

      // R7 back-to-back frames
      bus_read(A_STAT, r);
      bus_write(A_DATA, 8'h81);
      wait_irq(n);
      bus_read(A_STAT, r); check("R7 complete low while sending", r, 8'h01);
      bus_write(A_DATA, 8'h7E);
      wait_frame("R7 first of pair", 8'h81);
      repeat (2 * T) @(negedge clk);
      bus_read(A_STAT, r); check("R7 complete low between frames", r, 8'h01);
      wait_frame("R7 second of pair", 8'h7E);
      repeat (T) @(negedge clk);
      bus_read(A_STAT, r); check("R7 complete after pair", r, 8'h03);

      // R8 disable drops the pending byte
      bus_read(A_STAT, r);
      bus_write(A_DATA, 8'h11);
      wait_irq(n);
      bus_read(A_STAT, r);
      bus_write(A_DATA, 8'h22);
      check("R8 pending byte held", tx_irq, 0);
      bus_write(A_CTRL, 8'h02);
      @(negedge clk);
      check("R8 pending discarded", tx_irq, 1);
      wait_frame("R8 current frame finishes", 8'h11);
      repeat (12 * T) @(negedge clk);
      check("R8 no further frame", rxq.size(), 0);
      check("R8 line high", tx_line, 1);
      bus_read(A_STAT, r); check("R8 status idle", r, 8'h03);
      bus_write(A_CTRL, 8'h03);

      // R9 divisor change
      bus_write(A_DIV, 8'd6); T = 7;
      bus_read(A_DIV, r); check("R9 divisor readback", r, 6);
      send(8'hA5); send(8'h5A); send(8'hC3);

      check("R2 start and stop bits", stop_err, 0);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule